// File: doc/BRIEF.md
# Move-to-Front Translation Cache

This block is a fully associative cache of address translations. Its entries are held in recency order, and slot 0 is always the most recently used. A lookup compares the requested virtual page against every entry in parallel, together with the address-space identifier, the virtual-machine identifier, the hypervisor flag, the security state and the exception level. The hit with the lowest slot number wins and its physical page is returned in the same cycle.

Recency is kept by moving the entries themselves, with no pointer structure. A fill enters at slot 0, every other entry moves down one place and the last entry falls out. A hit outside a small protected window at the front is pulled to slot 0. A maintenance port removes entries in one of four ways: by security state, by address-space identifier, or by virtual page with or without the identifier. Each command is filtered by security tag, virtual-machine identifier and exception level. The block sits between an address-generation stage and a table walker. The walker fills the block on a miss, and system software issues the maintenance commands.

Top module: `mtf_tlb`

## Requirements
- R1: A lookup hits on a valid entry only when all of these hold: the page matches, the VMID matches, the hypervisor flag matches, the entry's non-secure tag is the inverse of the lookup's secure flag, the exception level matches, and either the ASID matches or the entry is global. The level rule is: for a target of 2 or 3 the entry level must be equal to it; for any other target the entry level must be 0 or 1. `lk_hit`, `lk_ppn` and `lk_slot` are combinational and report the lowest matching slot.
- R2: A non-debug hit at a slot above `MRU_WIN` (default 1) moves that entry to slot 0 at the next clock edge. The entries that were in slots 0 to the hit slot minus 1 each move down one place. Slots behind the hit slot do not change.
- R3: A non-debug hit at a slot at or below `MRU_WIN` leaves the order and contents unchanged.
- R4: A lookup with `lk_debug` set never changes the order or the contents.
- R5: An insert writes the new entry, valid, into slot 0 and moves every other entry down one place. The entry that was in the last slot is discarded.
- R6: `mt_op` = 0 (flush by security) invalidates every entry that meets all of these: it is valid, its non-secure tag is the inverse of `mt_secure`, its VMID equals `mt_vmid` or the command is secure, and its level matches `mt_el` under the R1 level rule. `mt_ign_el` forces the level match. Order is kept and no entry becomes valid.
- R7: `mt_op` = 1 (flush by ASID) uses the R6 conditions and also requires the entry ASID to equal `mt_asid`. In this mode `mt_ign_el` has no effect.
- R8: `mt_op` = 2 (flush by page with ASID) invalidates every valid entry that R1 would match, using the `mt_*` fields as the query. A global entry is removed whatever `mt_asid` holds.
- R9: `mt_op` = 3 (flush by page) works as R8 but ignores the ASID entirely.
- R10: Priority in a single cycle is: a maintenance command first, then an insert, then promotion. An insert that arrives with a command is dropped. A promotion is dropped when an insert or a command arrives in the same cycle. The lookup result is still reported in that cycle.
- R11: `mt_done` is high exactly in the cycle after each cycle in which `mt_valid` is high.
- R12: After reset every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_debug | input | 1 | Debug lookup, never reorders |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_vmid | input | 8 | Lookup virtual-machine identifier |
| lk_hyp | input | 1 | Lookup hypervisor flag |
| lk_secure | input | 1 | Lookup is secure |
| lk_el | input | 2 | Lookup target exception level |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page of the hit |
| lk_slot | output | 3 | Slot of the hit |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | 20 | New entry virtual page |
| ins_ppn | input | 20 | New entry physical page |
| ins_asid | input | 8 | New entry ASID |
| ins_vmid | input | 8 | New entry VMID |
| ins_hyp | input | 1 | New entry hypervisor flag |
| ins_ns | input | 1 | New entry non-secure tag |
| ins_el | input | 2 | New entry exception level |
| ins_global | input | 1 | New entry matches any ASID |
| mt_valid | input | 1 | Maintenance command valid |
| mt_op | input | 2 | Command: 0 security, 1 ASID, 2 page+ASID, 3 page |
| mt_secure | input | 1 | Command secure flag |
| mt_vmid | input | 8 | Current VMID for the command |
| mt_asid | input | 8 | Command ASID |
| mt_vpn | input | 20 | Command virtual page |
| mt_hyp | input | 1 | Command hypervisor flag |
| mt_el | input | 2 | Command target exception level |
| mt_ign_el | input | 1 | Force level match (security flush only) |
| mt_done | output | 1 | Command completed |

## Verification
The assertions check the movement rules on every cycle: the front slot after an insert or a promotion, the shift into the last slot, that nothing moves after a debug lookup or a hit inside the window, that a flush never validates or rewrites an entry, and the timing of `mt_done`. The match and invalidation rules can only be shown by the bench's scenarios. Those scenarios need the entry attributes set up deliberately: level targets 0 to 3 with and without the ignore flag, secure commands against foreign VMIDs, global entries under page flushes, and inserts or commands that collide with a promotion. A long pseudo-random sequence then compares every lookup against a recency model.

// File: rtl/mtf_tlb_pkg.sv
package mtf_tlb_pkg;

   typedef enum logic [1:0] {
      MT_SEC     = 2'd0,
      MT_ASID    = 2'd1,
      MT_VA_ASID = 2'd2,
      MT_VA      = 2'd3
   } mt_op_e;

   // Level rule: high targets need an exact level, low targets take 0 or 1.
   function automatic logic el_ok(input logic [1:0] tgt,
                                  input logic [1:0] ent,
                                  input logic       ign);
      if (ign)
         return 1'b1;
      if (tgt[1])
         return ent == tgt;
      return !ent[1];
   endfunction

endpackage

// File: rtl/mtf_tlb_cmp.sv
module mtf_tlb_cmp
   import mtf_tlb_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int VMID_W = 8
) (
   input  logic              e_valid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [VMID_W-1:0] e_vmid,
   input  logic              e_hyp,
   input  logic              e_ns,
   input  logic [1:0]        e_el,
   input  logic              e_glob,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   input  logic [VMID_W-1:0] q_vmid,
   input  logic              q_hyp,
   input  logic              q_sec,
   input  logic [1:0]        q_el,
   input  logic [1:0]        m_op,
   input  logic [VPN_W-1:0]  m_vpn,
   input  logic [ASID_W-1:0] m_asid,
   input  logic [VMID_W-1:0] m_vmid,
   input  logic              m_hyp,
   input  logic              m_sec,
   input  logic [1:0]        m_el,
   input  logic              m_ign,
   output logic              lk_match,
   output logic              fl_match
);

   logic tag_ok;
   logic va_hit;
   logic asid_ok;
   logic sec_ok;

   // Lookup path
   always_comb begin
      lk_match = e_valid && (e_vpn == q_vpn) && (e_vmid == q_vmid) &&
                 (e_hyp == q_hyp) && (e_ns == !q_sec) &&
                 el_ok(q_el, e_el, 1'b0) && (e_glob || (e_asid == q_asid));
   end

   // Maintenance path
   always_comb begin
      tag_ok  = e_valid && (e_ns == !m_sec);
      sec_ok  = tag_ok && ((e_vmid == m_vmid) || m_sec);
      va_hit  = tag_ok && (e_vpn == m_vpn) && (e_vmid == m_vmid) &&
                (e_hyp == m_hyp) && el_ok(m_el, e_el, 1'b0);
      asid_ok = e_glob || (e_asid == m_asid);
      unique case (mt_op_e'(m_op))
         MT_SEC:     fl_match = sec_ok && el_ok(m_el, e_el, m_ign);
         MT_ASID:    fl_match = sec_ok && (e_asid == m_asid) &&
                                el_ok(m_el, e_el, 1'b0);
         MT_VA_ASID: fl_match = va_hit && asid_ok;
         MT_VA:      fl_match = va_hit;
         default:    fl_match = 1'b0;
      endcase
   end

endmodule

// File: rtl/mtf_tlb_first.sv
module mtf_tlb_first #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  hits,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i])
            idx = IW'(i);
      end
      any = |hits;
   end

endmodule

// File: rtl/mtf_tlb_store.sv
module mtf_tlb_store #(
   parameter int N  = 8,
   parameter int W  = 64,
   parameter int IW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic [IW-1:0]       shift_top,
   input  logic [W-1:0]        front_dat,
   input  logic [N-1:0]        kill,
   output logic [N-1:0]        vld,
   output logic [N-1:0][W-1:0] dat
);

   logic [N-1:0]        vld_q;
   logic [N-1:0][W-1:0] dat_q;

   for (genvar s = 0; s < N; s++) begin : g_slot
      if (s == 0) begin : g_front
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[0] <= 1'b0;
               dat_q[0] <= '0;
            end else if (kill[0]) begin
               vld_q[0] <= 1'b0;
            end else if (shift_en) begin
               vld_q[0] <= 1'b1;
               dat_q[0] <= front_dat;
            end
         end
      end else begin : g_rest
         logic take;
         assign take = shift_en && (IW'(s) <= shift_top);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[s] <= 1'b0;
               dat_q[s] <= '0;
            end else if (kill[s]) begin
               vld_q[s] <= 1'b0;
            end else if (take) begin
               vld_q[s] <= vld_q[s-1];
               dat_q[s] <= dat_q[s-1];
            end
         end
      end
   end

   assign vld = vld_q;
   assign dat = dat_q;

endmodule

// File: rtl/mtf_tlb.sv
module mtf_tlb
   import mtf_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int MRU_WIN = 1,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int VMID_W  = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_debug,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VMID_W-1:0] lk_vmid,
   input  logic              lk_hyp,
   input  logic              lk_secure,
   input  logic [1:0]        lk_el,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [IDX_W-1:0]  lk_slot,
   input  logic              ins_valid,
   input  logic [VPN_W-1:0]  ins_vpn,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [ASID_W-1:0] ins_asid,
   input  logic [VMID_W-1:0] ins_vmid,
   input  logic              ins_hyp,
   input  logic              ins_ns,
   input  logic [1:0]        ins_el,
   input  logic              ins_global,
   input  logic              mt_valid,
   input  logic [1:0]        mt_op,
   input  logic              mt_secure,
   input  logic [VMID_W-1:0] mt_vmid,
   input  logic [ASID_W-1:0] mt_asid,
   input  logic [VPN_W-1:0]  mt_vpn,
   input  logic              mt_hyp,
   input  logic [1:0]        mt_el,
   input  logic              mt_ign_el,
   output logic              mt_done
);

   // Entry word layout, low to high
   localparam int O_VPN  = 0;
   localparam int O_PPN  = O_VPN + VPN_W;
   localparam int O_ASID = O_PPN + PPN_W;
   localparam int O_VMID = O_ASID + ASID_W;
   localparam int O_HYP  = O_VMID + VMID_W;
   localparam int O_NS   = O_HYP + 1;
   localparam int O_EL   = O_NS + 1;
   localparam int O_GLOB = O_EL + 2;
   localparam int WORD_W = O_GLOB + 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("mtf_tlb: ENTRIES must be at least 2");
   end
   if (MRU_WIN < 0 || MRU_WIN >= ENTRIES) begin : g_bad_win
      $error("mtf_tlb: MRU_WIN must lie in 0..ENTRIES-1");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1 || VMID_W < 1) begin : g_bad_w
      $error("mtf_tlb: field widths must be positive");
   end

   logic [ENTRIES-1:0]             st_vld;
   logic [ENTRIES-1:0][WORD_W-1:0] st_dat;
   logic [ENTRIES-1:0]             lk_vec;
   logic [ENTRIES-1:0]             fl_vec;
   logic                           any_hit;
   logic [IDX_W-1:0]               hit_idx;
   logic [WORD_W-1:0]              ins_word;
   logic                           ins_go;
   logic                           promote;
   logic                           far_hit;
   logic                           shift_en;
   logic [IDX_W-1:0]               shift_top;
   logic [WORD_W-1:0]              front_dat;
   logic [ENTRIES-1:0]             kill;
   logic                           done_q;

   assign ins_word = {ins_global, ins_el, ins_ns, ins_hyp,
                      ins_vmid, ins_asid, ins_ppn, ins_vpn};

   for (genvar s = 0; s < ENTRIES; s++) begin : g_cmp
      mtf_tlb_cmp #(
         .VPN_W  (VPN_W),
         .ASID_W (ASID_W),
         .VMID_W (VMID_W)
      ) u_cmp (
         .e_valid  (st_vld[s]),
         .e_vpn    (st_dat[s][O_VPN +: VPN_W]),
         .e_asid   (st_dat[s][O_ASID +: ASID_W]),
         .e_vmid   (st_dat[s][O_VMID +: VMID_W]),
         .e_hyp    (st_dat[s][O_HYP]),
         .e_ns     (st_dat[s][O_NS]),
         .e_el     (st_dat[s][O_EL +: 2]),
         .e_glob   (st_dat[s][O_GLOB]),
         .q_vpn    (lk_vpn),
         .q_asid   (lk_asid),
         .q_vmid   (lk_vmid),
         .q_hyp    (lk_hyp),
         .q_sec    (lk_secure),
         .q_el     (lk_el),
         .m_op     (mt_op),
         .m_vpn    (mt_vpn),
         .m_asid   (mt_asid),
         .m_vmid   (mt_vmid),
         .m_hyp    (mt_hyp),
         .m_sec    (mt_secure),
         .m_el     (mt_el),
         .m_ign    (mt_ign_el),
         .lk_match (lk_vec[s]),
         .fl_match (fl_vec[s])
      );
   end

   mtf_tlb_first #(
      .N  (ENTRIES),
      .IW (IDX_W)
   ) u_first (
      .hits (lk_vec),
      .any  (any_hit),
      .idx  (hit_idx)
   );

   assign lk_hit  = lk_valid && any_hit;
   assign lk_slot = hit_idx;
   assign lk_ppn  = st_dat[hit_idx][O_PPN +: PPN_W];

   // Window test: a zero-size window promotes every hit outside slot 0
   if (MRU_WIN == 0) begin : g_win0
      assign far_hit = (hit_idx != '0);
   end else begin : g_winn
      assign far_hit = (int'(hit_idx) > MRU_WIN);
   end

   // Priority: command, then insert, then promotion
   assign ins_go    = ins_valid && !mt_valid;
   assign promote   = lk_hit && !lk_debug && far_hit && !mt_valid && !ins_valid;
   assign shift_en  = ins_go || promote;
   assign shift_top = ins_go ? IDX_W'(ENTRIES - 1) : hit_idx;
   assign front_dat = ins_go ? ins_word : st_dat[hit_idx];
   assign kill      = mt_valid ? fl_vec : '0;

   mtf_tlb_store #(
      .N  (ENTRIES),
      .W  (WORD_W),
      .IW (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .shift_top (shift_top),
      .front_dat (front_dat),
      .kill      (kill),
      .vld       (st_vld),
      .dat       (st_dat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_q <= 1'b0;
      else
         done_q <= mt_valid;
   end

   assign mt_done = done_q;

endmodule

// File: rtl/mtf_tlb_chk.sv
module mtf_tlb_chk #(
   parameter int N       = 8,
   parameter int W       = 64,
   parameter int IW      = 3,
   parameter int MRU_WIN = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lk_valid,
   input logic                lk_debug,
   input logic                lk_hit,
   input logic [IW-1:0]       lk_slot,
   input logic                ins_valid,
   input logic                mt_valid,
   input logic                mt_done,
   input logic [W-1:0]        ins_word,
   input logic [N-1:0]        vld,
   input logic [N-1:0][W-1:0] dat
);

   logic lone_lk;
   assign lone_lk = lk_valid && lk_hit && !ins_valid && !mt_valid;

   // R1: a reported hit always points at a valid slot
   a_r1_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> vld[lk_slot]);

   // R5: the new entry lands at the front
   a_r5_insert_front: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !mt_valid) |=> (vld[0] && dat[0] == $past(ins_word)));

   // R5: the slot before the last moves into the last
   a_r5_evict_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !mt_valid) |=>
         (dat[N-1] == $past(dat[N-2]) && vld[N-1] == $past(vld[N-2])));

   // R2: a far hit is pulled to the front
   a_r2_promote: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_lk && !lk_debug && int'(lk_slot) > MRU_WIN) |=>
         (vld[0] && dat[0] == $past(dat[lk_slot])));

   // R3: a hit inside the window changes nothing
   a_r3_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_lk && !lk_debug && int'(lk_slot) <= MRU_WIN) |=>
         ($stable(dat) && $stable(vld)));

   // R4: debug lookups change nothing
   a_r4_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_debug && !ins_valid && !mt_valid) |=>
         ($stable(dat) && $stable(vld)));

   // R6: a flush only clears valid bits and leaves the words in place
   a_r6_flush_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      mt_valid |=> (((vld & ~$past(vld)) == '0) && $stable(dat)));

   // R11: completion follows a command by exactly one cycle
   a_r11_done: assert property (@(posedge clk) disable iff (!rst_n)
      mt_valid |=> mt_done);

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mt_valid |=> !mt_done);

endmodule

bind mtf_tlb mtf_tlb_chk #(
   .N       (ENTRIES),
   .W       (WORD_W),
   .IW      (IDX_W),
   .MRU_WIN (MRU_WIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_debug  (lk_debug),
   .lk_hit    (lk_hit),
   .lk_slot   (lk_slot),
   .ins_valid (ins_valid),
   .mt_valid  (mt_valid),
   .mt_done   (mt_done),
   .ins_word  (ins_word),
   .vld       (st_vld),
   .dat       (st_dat)
);

// File: tb/mtf_tlb_bench.sv
module mtf_tlb_bench;

   localparam int N  = 4;
   localparam int VW = 4;
   localparam int PW = 6;
   localparam int AW = 2;
   localparam int MW = 2;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          lk_valid = 0, lk_debug = 0, lk_hyp = 0, lk_secure = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic [MW-1:0] lk_vmid = '0;
   logic [1:0]    lk_el = '0;
   logic          lk_hit;
   logic [PW-1:0] lk_ppn;
   logic [IW-1:0] lk_slot;
   logic          ins_valid = 0, ins_hyp = 0, ins_ns = 0, ins_global = 0;
   logic [VW-1:0] ins_vpn = '0;
   logic [PW-1:0] ins_ppn = '0;
   logic [AW-1:0] ins_asid = '0;
   logic [MW-1:0] ins_vmid = '0;
   logic [1:0]    ins_el = '0;
   logic          mt_valid = 0, mt_secure = 0, mt_hyp = 0, mt_ign_el = 0;
   logic [1:0]    mt_op = '0;
   logic [MW-1:0] mt_vmid = '0;
   logic [AW-1:0] mt_asid = '0;
   logic [VW-1:0] mt_vpn = '0;
   logic [1:0]    mt_el = '0;
   logic          mt_done;

   mtf_tlb #(
      .ENTRIES (N), .MRU_WIN (1), .VPN_W (VW), .PPN_W (PW),
      .ASID_W (AW), .VMID_W (MW)
   ) u_mtf_tlb (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_debug (lk_debug), .lk_vpn (lk_vpn),
      .lk_asid (lk_asid), .lk_vmid (lk_vmid), .lk_hyp (lk_hyp),
      .lk_secure (lk_secure), .lk_el (lk_el), .lk_hit (lk_hit),
      .lk_ppn (lk_ppn), .lk_slot (lk_slot),
      .ins_valid (ins_valid), .ins_vpn (ins_vpn), .ins_ppn (ins_ppn),
      .ins_asid (ins_asid), .ins_vmid (ins_vmid), .ins_hyp (ins_hyp),
      .ins_ns (ins_ns), .ins_el (ins_el), .ins_global (ins_global),
      .mt_valid (mt_valid), .mt_op (mt_op), .mt_secure (mt_secure),
      .mt_vmid (mt_vmid), .mt_asid (mt_asid), .mt_vpn (mt_vpn),
      .mt_hyp (mt_hyp), .mt_el (mt_el), .mt_ign_el (mt_ign_el),
      .mt_done (mt_done)
   );

   typedef struct packed {
      logic          v;
      logic [VW-1:0] vpn;
      logic [PW-1:0] ppn;
      logic [AW-1:0] asid;
      logic [MW-1:0] vmid;
      logic          hyp;
      logic          ns;
      logic [1:0]    el;
      logic          g;
   } ment_t;

   ment_t       m [N];
   int          n_chk = 0;
   int          n_fail = 0;
   int unsigned seed = 32'h1234_5679;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic bit b_el(input int tgt, input int ent, input bit ign);
      if (ign) return 1'b1;
      if (tgt >= 2) return ent == tgt;
      return ent <= 1;
   endfunction

   function automatic int m_find();
      for (int i = 0; i < N; i++) begin
         if (m[i].v && m[i].vpn == lk_vpn && m[i].vmid == lk_vmid &&
             m[i].hyp == lk_hyp && m[i].ns == !lk_secure &&
             b_el(int'(lk_el), int'(m[i].el), 1'b0) &&
             (m[i].g || m[i].asid == lk_asid))
            return i;
      end
      return -1;
   endfunction

   function automatic bit m_kill(input ment_t e);
      bit base;
      base = e.v && (e.ns == !mt_secure);
      case (mt_op)
         2'd0: return base && (e.vmid == mt_vmid || mt_secure) &&
                      b_el(int'(mt_el), int'(e.el), mt_ign_el);
         2'd1: return base && (e.vmid == mt_vmid || mt_secure) &&
                      e.asid == mt_asid && b_el(int'(mt_el), int'(e.el), 1'b0);
         default: begin
            bit va;
            va = base && e.vpn == mt_vpn && e.vmid == mt_vmid &&
                 e.hyp == mt_hyp && b_el(int'(mt_el), int'(e.el), 1'b0);
            if (mt_op == 2'd2) return va && (e.g || e.asid == mt_asid);
            return va;
         end
      endcase
   endfunction

   // One cycle: inputs already driven after a falling edge.
   // want: -2 no explicit expectation, -1 miss, else slot.
   task automatic tick(input int want, input string req);
      int    exp;
      bit    prev_mt;
      ment_t tmp;
      #1;
      exp = m_find();
      if (lk_valid) begin
         chk({req, " hit"}, int'(lk_hit), int'(exp >= 0));
         if (exp >= 0) begin
            chk({req, " slot"}, int'(lk_slot), exp);
            chk({req, " ppn"}, int'(lk_ppn), int'(m[exp].ppn));
         end
         if (want != -2) begin
            chk({req, " expected slot"}, lk_hit ? int'(lk_slot) : -1, want);
         end
      end
      @(posedge clk);
      prev_mt = mt_valid;
      if (mt_valid) begin
         for (int i = 0; i < N; i++)
            if (m_kill(m[i])) m[i].v = 1'b0;
      end else if (ins_valid) begin
         for (int i = N - 1; i > 0; i--) m[i] = m[i-1];
         m[0] = '{v: 1'b1, vpn: ins_vpn, ppn: ins_ppn, asid: ins_asid,
                  vmid: ins_vmid, hyp: ins_hyp, ns: ins_ns, el: ins_el,
                  g: ins_global};
      end else if (lk_valid && !lk_debug && exp > 1) begin
         tmp = m[exp];
         for (int i = exp; i > 0; i--) m[i] = m[i-1];
         m[0] = tmp;
      end
      @(negedge clk);
      chk("R11 done", int'(mt_done), int'(prev_mt));
      lk_valid = 0; ins_valid = 0; mt_valid = 0;
   endtask

   task automatic set_lk(input int vpn, input bit dbg, input int el,
                         input int asid, input bit sec, input int vmid,
                         input bit hyp);
      lk_valid = 1; lk_debug = dbg; lk_vpn = VW'(vpn); lk_el = 2'(el);
      lk_asid = AW'(asid); lk_secure = sec; lk_vmid = MW'(vmid); lk_hyp = hyp;
   endtask

   task automatic set_ins(input int vpn, input int el, input int asid,
                          input bit ns, input int vmid, input bit g,
                          input bit hyp, input int ppn);
      ins_valid = 1; ins_vpn = VW'(vpn); ins_el = 2'(el); ins_asid = AW'(asid);
      ins_ns = ns; ins_vmid = MW'(vmid); ins_global = g; ins_hyp = hyp;
      ins_ppn = PW'(ppn);
   endtask

   task automatic set_mt(input int op, input int el, input bit ign,
                         input bit sec, input int vmid, input int asid,
                         input int vpn, input bit hyp);
      mt_valid = 1; mt_op = 2'(op); mt_el = 2'(el); mt_ign_el = ign;
      mt_secure = sec; mt_vmid = MW'(vmid); mt_asid = AW'(asid);
      mt_vpn = VW'(vpn); mt_hyp = hyp;
   endtask

   task automatic look(input int vpn, input int want, input string req,
                       input bit dbg = 1, input int el = 0, input int asid = 1,
                       input bit sec = 0, input int vmid = 1);
      set_lk(vpn, dbg, el, asid, sec, vmid, 1'b0);
      tick(want, req);
   endtask

   task automatic ins(input int vpn, input int el = 0, input int asid = 1,
                      input bit ns = 1, input int vmid = 1, input bit g = 0);
      set_ins(vpn, el, asid, ns, vmid, g, 1'b0, vpn + 10);
      tick(-2, "R5");
   endtask

   task automatic fl(input int op, input int el = 0, input bit ign = 0,
                     input bit sec = 0, input int vmid = 1, input int asid = 1,
                     input int vpn = 0);
      set_mt(op, el, ign, sec, vmid, asid, vpn, 1'b0);
      tick(-2, "R6");
   endtask

   function automatic int unsigned nx();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R12: empty after reset
      look(1, -1, "R12");
      look(0, -1, "R12", 1, 0, 0, 0, 0);

      // R5 / R1: fill in order, newest at the front
      ins(1); ins(2); ins(3); ins(4);
      look(1, 3, "R1");
      look(4, 0, "R5");
      ins(5);
      look(1, -1, "R5 evicted");
      look(2, 3, "R5");

      // R2: far hit goes to the front
      look(2, 3, "R2", 0);
      look(2, 0, "R2");
      look(5, 1, "R2");
      look(3, 3, "R2");

      // R3: hit inside the window leaves order alone
      look(5, 1, "R3", 0);
      look(5, 1, "R3");
      look(2, 0, "R3");

      // R4: debug lookup at a far slot does nothing
      look(3, 3, "R4");
      look(3, 3, "R4");

      // R10: insert wins over promotion, result still reported
      set_lk(3, 0, 0, 1, 0, 1, 0);
      set_ins(6, 0, 1, 1, 1, 0, 0, 16);
      tick(3, "R10");
      look(4, 3, "R10");
      look(3, -1, "R10");
      // R10: command drops a same-cycle insert
      set_mt(1, 0, 0, 0, 1, 3, 0, 0);
      set_ins(7, 0, 1, 1, 1, 0, 0, 17);
      tick(-2, "R10");
      look(7, -1, "R10");

      // R1: attribute mismatches
      look(6, -1, "R1", 1, 0, 2);
      look(6, -1, "R1", 1, 2, 1);
      look(6, -1, "R1", 1, 0, 1, 1);
      look(6, 0, "R1");

      // R8: page flush with ASID, global entry
      ins(8, 0, 0, 1, 1, 1);
      look(8, 0, "R1", 1, 0, 3);
      fl(2, 0, 0, 0, 1, 2, 6);
      look(6, 1, "R8");
      fl(2, 0, 0, 0, 1, 1, 6);
      look(6, -1, "R8");
      fl(2, 0, 0, 0, 1, 3, 8);
      look(8, -1, "R8", 1, 0, 3);

      // R9: page flush ignoring ASID, security tag must agree
      fl(3, 0, 0, 1, 1, 3, 2);
      look(2, 2, "R9");
      fl(3, 0, 0, 0, 1, 3, 2);
      look(2, -1, "R9");

      // R7: ASID flush, level ignore has no effect here
      ins(9, 2, 2);
      fl(1, 0, 1, 0, 1, 2);
      look(9, 0, "R7", 1, 2, 2);
      fl(1, 2, 0, 0, 1, 2);
      look(9, -1, "R7", 1, 2, 2);

      // R6: level rule for security flush
      fl(0, 0, 1);
      ins(0, 0); ins(1, 1); ins(2, 2); ins(3, 3);
      fl(0, 2, 0);
      look(2, -1, "R6", 1, 2);
      look(3, 0, "R6", 1, 3);
      fl(0, 0, 0, 0, 2);
      look(0, 3, "R6", 1, 0);
      fl(0, 0, 0);
      look(1, -1, "R6", 1, 1);
      look(0, -1, "R6", 1, 0);
      look(3, 0, "R6", 1, 3);
      fl(0, 0, 1);
      look(3, -1, "R6", 1, 3);
      // secure flush ignores VMID, non-secure flush leaves secure entries
      ins(4, 0, 1, 0, 2);
      fl(0, 0, 0, 0, 2);
      look(4, 0, "R6", 1, 0, 1, 1, 2);
      fl(0, 0, 0, 1, 0);
      look(4, -1, "R6", 1, 0, 1, 1, 2);

      // R1: pseudo-random sequence against the recency model
      for (int it = 0; it < 600; it++) begin
         int unsigned r;
         int unsigned kind;
         r = nx();
         kind = r % 8;
         if (kind <= 2) begin
            set_ins(int'(r[7:6]), int'(r[9:8]), int'(r[10]), r[11],
                    int'(r[12]), r[13] & r[14], r[15], int'(r[21:16]));
            tick(-2, "R5 random");
         end else if (kind <= 5 || kind == 7) begin
            int sel;
            sel = int'(r[9:8]);
            if (r[10] && m[sel].v)
               set_lk(int'(m[sel].vpn), r[11], int'(m[sel].el),
                      r[12] ? int'(r[14:13]) : int'(m[sel].asid),
                      !m[sel].ns, int'(m[sel].vmid), m[sel].hyp);
            else
               set_lk(int'(r[17:16]), r[11], int'(r[19:18]), int'(r[20]),
                      r[21], int'(r[22]), r[23]);
            if (kind == 7)
               set_ins(int'(r[25:24]), 0, 1, 1, 1, 0, 0, int'(r[31:26]));
            tick(-2, "R1 random");
         end else begin
            set_mt(int'(r[9:8]), int'(r[11:10]), r[12], r[13], int'(r[14]),
                   int'(r[15]), int'(r[17:16]), r[18]);
            tick(-2, "R6 random");
         end
      end

      report();
      $finish;
   end

endmodule